// File: doc/BRIEF.md
# Flash LED Current Ramp Sequencer

This block drives the digital code of the LED current source in a camera flash driver. It reads a small set of control fields: flash level, assist (torch) level, an enable bit, a mode bit and a four-bit flash duration. From these it produces a 5-bit current DAC code and an enable for the boost converter. The LED current never jumps. When the LED turns on, the boost comes up during a settling phase with the code at zero. The code then rises by one count per step until it reaches the level that was asked for. When the LED turns off, the code falls back to zero one count at all times.

A flash ends by itself. After the programmed time the sequencer ramps the current down and sends a one-cycle request to the register file to clear the enable and mode bits. Assist light stays on until software writes both bits to zero, or until it asks for a flash. An assist-to-flash request climbs from the assist code to the flash code without a second settling phase. A fault input shuts everything off on the next clock. All timing counts pulses of a slow tick input, nominally 1 MHz.

Top module: `flash_ramp_seq`

## Requirements
- R1: While reset is high, and on the first clock after it, `dac_code` is 0, `boost_en` is 0 and `mode_clr` is 0, whatever the control inputs are.
- R2: The target code is round(mA × 31 / 320). The flash level 0/1/2/3 (260/280/300/320 mA) gives code 25/27/29/31. The assist level 0/1 (52/72 mA) gives code 5/7. The code never goes above the target of the sequence that is running.
- R3: When idle and armed, `cfg_led_on`=1 raises `boost_en` on the next clock. The code then stays 0 for INIT_TICKS ticks and after that rises by exactly 1 every STEP_TICKS ticks until it reaches the target. Without a tick, no time passes.
- R4: In flash mode (`cfg_flash_mode`=1 at start) the code holds at target for (timer+1)×UNIT_TICKS ticks, where timer is the 4-bit field latched at the start. Then `mode_clr` pulses for one cycle and ramp-down begins.
- R5: A flash ramp-down lowers the code by 1 every STEP_TICKS ticks to 0, holds 0 for one more step (N+1 steps in all) and then drops `boost_en`. Whenever `boost_en` is 0, the code is 0.
- R6: Assist mode (mode bit 0 at start) holds its target for as long as enable=1 and mode=0. On enable=0/mode=0 it ramps down in N steps, with `boost_en` falling in the same cycle the code reaches 0, and it does not pulse `mode_clr`.
- R7: During a running flash, writes that ask for assist (enable=1, mode=0) or a new flash level are ignored, so the hold length and code do not change. Only enable=0/mode=0 ends the flash early, without a `mode_clr` pulse.
- R8: During assist hold, mode=1 (with enable 1 or 0) switches to flash. The code climbs from the assist code to the flash code one count per step with no settling phase. The timer field is latched at the switch, and the full flash with its `mode_clr` pulse follows.
- R9: `fault_abort`=1 forces code 0 and `boost_en` 0 at the next clock and skips the ramp-down. `mode_clr` pulses in that cycle only if a sequence was active.
- R10: After any return to idle, no new sequence starts until `cfg_led_on` has been seen at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base strobe, one clock wide, nominally 1 MHz |
| cfg_flash_lvl | input | 2 | Flash current select, 0..3 |
| cfg_assist_lvl | input | 1 | Assist current select |
| cfg_led_on | input | 1 | Enable bit from the control register |
| cfg_flash_mode | input | 1 | Mode bit: 1 flash, 0 assist |
| cfg_timer | input | 4 | Flash duration code |
| fault_abort | input | 1 | Immediate shutdown from fault logic |
| dac_code | output | 5 | Current source code |
| boost_en | output | 1 | Boost converter enable |
| mode_clr | output | 1 | One-cycle request to clear enable and mode bits |

## Verification
The hardest state to reach is an assist-to-flash switch. It needs an assist sequence that has settled at its hold level, and then a write of enable=0 with mode=1. That same write would do nothing from idle. The bench gets there by holding assist for a while and then writing that value. It follows the code as it climbs from 7 to 25 with no settling phase, and then waits for the timer's clear pulse. A second awkward case is a tick stall during the settling phase. The bench holds the tick low after a start and then resumes it, and checks that the ramp picks up exactly where the count stopped.

// File: rtl/flash_ramp_pkg.sv
package flash_ramp_pkg;

    localparam int CODE_W        = 5;
    localparam int FULL_CODE     = (1 << CODE_W) - 1;
    localparam int FULL_MA       = 320;
    localparam int FLASH_BASE_MA = 260;
    localparam int FLASH_STEP_MA = 20;
    localparam int ASSIST_BASE_MA = 52;
    localparam int ASSIST_STEP_MA = 20;
    localparam int FLASH_LEVELS  = 4;
    localparam int TIMER_W       = 4;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_UP,
        ST_HOLD,
        ST_DOWN
    } seq_state_e;

    typedef struct packed {
        logic [1:0]         flash_lvl;
        logic               assist_lvl;
        logic               led_on;
        logic               flash_mode;
        logic [TIMER_W-1:0] timer;
    } ctrl_t;

    function automatic code_t ma_to_code(input int unsigned ma);
        int unsigned q;
        q = (ma * FULL_CODE + FULL_MA / 2) / FULL_MA;
        return q[CODE_W-1:0];
    endfunction

    function automatic int unsigned flash_ma(input int unsigned lvl);
        return FLASH_BASE_MA + FLASH_STEP_MA * lvl;
    endfunction

    function automatic int unsigned assist_ma(input int unsigned lvl);
        return ASSIST_BASE_MA + ASSIST_STEP_MA * lvl;
    endfunction

endpackage

// File: rtl/frs_level_map.sv
module frs_level_map
    import flash_ramp_pkg::*;
(
    input  logic [1:0] flash_lvl,
    input  logic       assist_lvl,
    output code_t      flash_code,
    output code_t      assist_code
);

    code_t flash_tbl [FLASH_LEVELS];

    for (genvar i = 0; i < FLASH_LEVELS; i++) begin : g_flash
        assign flash_tbl[i] = ma_to_code(flash_ma(i));
    end

    assign flash_code  = flash_tbl[flash_lvl];
    assign assist_code = assist_lvl ? ma_to_code(assist_ma(1)) : ma_to_code(assist_ma(0));

endmodule

// File: rtl/frs_step_pacer.sv
module frs_step_pacer #(
    parameter int INIT_TICKS = 300,
    parameter int STEP_TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic init_phase,
    input  logic tick,
    output logic step_done
);

    localparam int MAX_TICKS = (INIT_TICKS > STEP_TICKS) ? INIT_TICKS : STEP_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    assign lim       = init_phase ? CNT_W'(INIT_TICKS - 1) : CNT_W'(STEP_TICKS - 1);
    assign step_done = run && tick && (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst || !run || step_done) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_PACER_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= lim)) else $error("pacer count beyond limit"); // R3

endmodule

// File: rtl/frs_flash_timer.sv
module frs_flash_timer
    import flash_ramp_pkg::*;
#(
    parameter int UNIT_TICKS = 30000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               tick,
    input  logic [TIMER_W-1:0] dur_code,
    output logic               expired
);

    localparam int TMR_W = $clog2((1 << TIMER_W) * UNIT_TICKS + 1);

    logic [TMR_W-1:0] cnt_q;
    logic [TMR_W-1:0] lim;

    assign lim     = (TMR_W'(dur_code) + TMR_W'(1)) * TMR_W'(UNIT_TICKS) - TMR_W'(1);
    assign expired = run && tick && (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst || !run || expired) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        expired |=> !expired) else $error("timer expired twice in a row"); // R4

endmodule

// File: rtl/flash_ramp_seq.sv
module flash_ramp_seq
    import flash_ramp_pkg::*;
#(
    parameter int INIT_TICKS = 300,
    parameter int STEP_TICKS = 16,
    parameter int UNIT_TICKS = 30000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic [1:0]  cfg_flash_lvl,
    input  logic        cfg_assist_lvl,
    input  logic        cfg_led_on,
    input  logic        cfg_flash_mode,
    input  logic [3:0]  cfg_timer,
    input  logic        fault_abort,
    output logic [4:0]  dac_code,
    output logic        boost_en,
    output logic        mode_clr
);

    ctrl_t ctrl;
    assign ctrl = '{flash_lvl: cfg_flash_lvl, assist_lvl: cfg_assist_lvl,
                    led_on: cfg_led_on, flash_mode: cfg_flash_mode, timer: cfg_timer};

    seq_state_e         state_q;
    code_t              code_q, target_q;
    logic               is_flash_q, armed_q, boost_q, clr_q;
    logic [TIMER_W-1:0] dur_q;

    code_t flash_code, assist_code;
    logic  step_done, expired, req_off, pacer_run, timer_run;

    assign req_off   = !ctrl.led_on && !ctrl.flash_mode;
    assign pacer_run = (state_q == ST_INIT) || (state_q == ST_UP) || (state_q == ST_DOWN);
    assign timer_run = (state_q == ST_HOLD) && is_flash_q;

    frs_level_map u_map (
        .flash_lvl   (ctrl.flash_lvl),
        .assist_lvl  (ctrl.assist_lvl),
        .flash_code  (flash_code),
        .assist_code (assist_code)
    );

    frs_step_pacer #(.INIT_TICKS(INIT_TICKS), .STEP_TICKS(STEP_TICKS)) u_pacer (
        .clk        (clk),
        .rst        (rst),
        .run        (pacer_run),
        .init_phase (state_q == ST_INIT),
        .tick       (tick),
        .step_done  (step_done)
    );

    frs_flash_timer #(.UNIT_TICKS(UNIT_TICKS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (timer_run),
        .tick     (tick),
        .dur_code (dur_q),
        .expired  (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            code_q     <= '0;
            target_q   <= '0;
            is_flash_q <= 1'b0;
            dur_q      <= '0;
            armed_q    <= 1'b1;
            boost_q    <= 1'b0;
            clr_q      <= 1'b0;
        end else begin
            clr_q <= 1'b0;
            if (fault_abort) begin
                clr_q   <= (state_q != ST_IDLE);
                state_q <= ST_IDLE;
                code_q  <= '0;
                boost_q <= 1'b0;
                armed_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (!ctrl.led_on) begin
                            armed_q <= 1'b1;
                        end else if (armed_q) begin
                            state_q    <= ST_INIT;
                            boost_q    <= 1'b1;
                            code_q     <= '0;
                            is_flash_q <= ctrl.flash_mode;
                            target_q   <= ctrl.flash_mode ? flash_code : assist_code;
                            dur_q      <= ctrl.timer;
                        end
                    end
                    ST_INIT: begin
                        if (step_done) state_q <= ST_UP;
                    end
                    ST_UP: begin
                        if (step_done) begin
                            code_q <= code_q + 1'b1;
                            if (code_q + 1'b1 == target_q) state_q <= ST_HOLD;
                        end
                    end
                    ST_HOLD: begin
                        if (is_flash_q) begin
                            if (expired) begin
                                state_q <= ST_DOWN;
                                clr_q   <= 1'b1;
                            end else if (req_off) begin
                                state_q <= ST_DOWN;
                            end
                        end else if (ctrl.flash_mode) begin
                            is_flash_q <= 1'b1;
                            target_q   <= flash_code;
                            dur_q      <= ctrl.timer;
                            state_q    <= ST_UP;
                        end else if (!ctrl.led_on) begin
                            state_q <= ST_DOWN;
                        end
                    end
                    ST_DOWN: begin
                        if (step_done) begin
                            if (code_q != '0) code_q <= code_q - 1'b1;
                            if ((code_q == '0) || (code_q == code_t'(1) && !is_flash_q)) begin
                                state_q <= ST_IDLE;
                                boost_q <= 1'b0;
                                armed_q <= 1'b0;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign dac_code = code_q;
    assign boost_en = boost_q;
    assign mode_clr = clr_q;

    AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !boost_en |-> (dac_code == '0)) else $error("code nonzero with boost off"); // R5

    AST_ABORT_DARK: assert property (@(posedge clk) disable iff (rst)
        fault_abort |=> (dac_code == '0 && !boost_en)) else $error("abort not honoured"); // R9

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        !fault_abort |=> (({1'b0, dac_code} <= {1'b0, $past(dac_code)} + 6'd1) &&
                          ({1'b0, $past(dac_code)} <= {1'b0, dac_code} + 6'd1)))
        else $error("code jumped by more than one"); // R3

    AST_CODE_CAP: assert property (@(posedge clk) disable iff (rst)
        boost_en |-> (dac_code <= target_q)) else $error("code above target"); // R2

    AST_CLR_PULSE: assert property (@(posedge clk) disable iff (rst)
        mode_clr |=> !mode_clr) else $error("clear request longer than one cycle"); // R4

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !armed_q && !fault_abort) |=> !boost_en)
        else $error("restart without enable low"); // R10

endmodule

// File: tb/sim_flash_ramp_seq.sv
module sim_flash_ramp_seq;

    localparam int INIT_T = 5;
    localparam int STEP_T = 2;
    localparam int UNIT_T = 20;
    localparam int NVEC   = 4;
    // {flash level, timer code, expected code}
    localparam logic [10:0] VEC [NVEC] = '{
        {2'd0, 4'd0,  5'd25},
        {2'd1, 4'd3,  5'd27},
        {2'd2, 4'd1,  5'd29},
        {2'd3, 4'd15, 5'd31}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic [1:0] cfg_flash_lvl = 2'd0;
    logic       cfg_assist_lvl = 1'b0;
    logic       cfg_led_on = 1'b0;
    logic       cfg_flash_mode = 1'b0;
    logic [3:0] cfg_timer = 4'd0;
    logic       fault_abort = 1'b0;
    logic [4:0] dac_code;
    logic       boost_en;
    logic       mode_clr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flash_ramp_seq #(.INIT_TICKS(INIT_T), .STEP_TICKS(STEP_T), .UNIT_TICKS(UNIT_T)) u0 (
        .clk(clk), .rst(rst), .tick(tick),
        .cfg_flash_lvl(cfg_flash_lvl), .cfg_assist_lvl(cfg_assist_lvl),
        .cfg_led_on(cfg_led_on), .cfg_flash_mode(cfg_flash_mode), .cfg_timer(cfg_timer),
        .fault_abort(fault_abort),
        .dac_code(dac_code), .boost_en(boost_en), .mode_clr(mode_clr)
    );

    task automatic expect3(input string req, input int code, input bit bst, input bit clr);
        n_chk++;
        if (dac_code !== 5'(code) || boost_en !== bst || mode_clr !== clr) begin
            n_bad++;
            $display("FAIL %s: code=%0d exp %0d boost=%0b exp %0b clr=%0b exp %0b",
                     req, dac_code, code, boost_en, bst, mode_clr, clr);
        end
    endtask

    task automatic set_cfg(input bit en, input bit md);
        cfg_led_on = en;
        cfg_flash_mode = md;
    endtask

    // ramp-up: code 0 for the first p samples, then +1 every STEP_T edges
    task automatic check_up(input string req, input int p, input int s, input int n);
        for (int e = 0; e <= p + STEP_T * (n - s); e++) begin
            @(negedge clk);
            expect3(req, (e < p) ? s : s + (e - p) / STEP_T, 1'b1, 1'b0);
        end
    endtask

    task automatic check_hold(input string req, input int n, input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            expect3(req, n, 1'b1, 1'b0);
        end
    endtask

    task automatic check_down(input string req, input int n, input bit tail, input bit clr);
        int last;
        last = tail ? STEP_T * (n + 1) : STEP_T * n;
        for (int d = 0; d <= last; d++) begin
            @(negedge clk);
            expect3(req, (d >= STEP_T * n) ? 0 : n - d / STEP_T, d < last, clr && d == 0);
        end
    endtask

    task automatic check_idle(input string req, input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            expect3(req, 0, 1'b0, 1'b0);
        end
    endtask

    initial begin
        cfg_flash_lvl = 2'd3;
        set_cfg(1'b1, 1'b1);
        repeat (3) @(negedge clk);
        expect3("R1 in reset", 0, 1'b0, 1'b0);
        set_cfg(1'b0, 1'b0);
        rst = 1'b0;
        check_idle("R1 after reset", 3);

        // vector table: flash at each level and several timer codes
        for (int v = 0; v < NVEC; v++) begin
            cfg_flash_lvl = VEC[v][10:9];
            cfg_timer     = VEC[v][8:5];
            set_cfg(1'b1, 1'b1);
            check_up("R2 R3 flash up", INIT_T, 0, int'(VEC[v][4:0]));
            check_hold("R4 flash hold", int'(VEC[v][4:0]), (int'(VEC[v][8:5]) + 1) * UNIT_T - 1);
            check_down("R5 flash down", int'(VEC[v][4:0]), 1'b1, 1'b1);
            check_idle("R10 no restart", 10);
            set_cfg(1'b0, 1'b0);
            @(negedge clk);
        end

        // R6 assist at both levels, ended by 00
        for (int a = 0; a < 2; a++) begin
            cfg_assist_lvl = a[0];
            set_cfg(1'b1, 1'b0);
            check_up("R2 R6 assist up", INIT_T, 0, a ? 7 : 5);
            check_hold("R6 assist stays", a ? 7 : 5, 60);
            set_cfg(1'b0, 1'b0);
            check_down("R6 assist down", a ? 7 : 5, 1'b0, 1'b0);
            check_idle("R6 idle", 3);
        end

        // R7 writes during flash are ignored
        cfg_flash_lvl = 2'd1;
        cfg_timer = 4'd0;
        set_cfg(1'b1, 1'b1);
        check_up("R7 up", INIT_T, 0, 27);
        check_hold("R7 hold", 27, 5);
        cfg_flash_lvl = 2'd3;
        set_cfg(1'b1, 1'b0);
        check_hold("R7 ignore assist", 27, UNIT_T - 1 - 5);
        check_down("R7 down", 27, 1'b1, 1'b1);
        set_cfg(1'b0, 1'b0);
        check_idle("R10 idle", 2);

        // R7 early end by 00
        cfg_flash_lvl = 2'd0;
        cfg_timer = 4'd15;
        set_cfg(1'b1, 1'b1);
        check_up("R7 up2", INIT_T, 0, 25);
        check_hold("R7 hold2", 25, 10);
        set_cfg(1'b0, 1'b0);
        check_down("R7 early off", 25, 1'b1, 1'b0);
        check_idle("R7 idle", 2);

        // R8 assist to flash via 10 -> 01
        cfg_assist_lvl = 1'b1;
        set_cfg(1'b1, 1'b0);
        check_up("R8 assist up", INIT_T, 0, 7);
        check_hold("R8 assist hold", 7, 30);
        cfg_flash_lvl = 2'd0;
        cfg_timer = 4'd1;
        set_cfg(1'b0, 1'b1);
        check_up("R8 climb", 0, 7, 25);
        check_hold("R8 flash hold", 25, 2 * UNIT_T - 1);
        check_down("R8 flash down", 25, 1'b1, 1'b1);
        set_cfg(1'b0, 1'b0);
        check_idle("R8 idle", 2);

        // R3 stalled tick during settling
        tick = 1'b0;
        cfg_assist_lvl = 1'b0;
        set_cfg(1'b1, 1'b0);
        check_hold("R3 no tick", 0, 30);
        tick = 1'b1;
        check_up("R3 resume", INIT_T - 1, 0, 5);
        set_cfg(1'b0, 1'b0);
        check_down("R3 down", 5, 1'b0, 1'b0);
        check_idle("R3 idle", 2);

        // R9 abort mid ramp, then R10 no restart while enable stays high
        cfg_flash_lvl = 2'd3;
        set_cfg(1'b1, 1'b1);
        check_up("R9 pre", INIT_T, 0, 3);
        fault_abort = 1'b1;
        @(negedge clk);
        expect3("R9 abort", 0, 1'b0, 1'b1);
        fault_abort = 1'b0;
        check_idle("R10 after abort", 15);
        set_cfg(1'b0, 1'b0);
        @(negedge clk);
        fault_abort = 1'b1;
        @(negedge clk);
        expect3("R9 idle abort", 0, 1'b0, 1'b0);
        fault_abort = 1'b0;
        @(negedge clk);
        set_cfg(1'b1, 1'b1);
        @(negedge clk);
        expect3("R10 rearmed", 0, 1'b1, 1'b0);
        set_cfg(1'b0, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule